// File: doc/BRIEF.md
# Two-Bit Branch Prediction Controller

This block steers the fetch address of a five-stage in-order pipeline around conditional branches and repairs the pipeline when it guesses wrong. While an instruction is in fetch, a table of two-bit saturating counters is read using the low bits of its word address. If the fetch-side predecoder marks the instruction as a conditional branch and the counter leans taken, fetch goes straight to the externally computed branch target. Otherwise fetch moves on to the sequential address.

The prediction bit and the predicted target ride along with the instruction into decode. There, the branch outcome and target are resolved by logic outside this block. The block compares them with what was predicted, trains the counter for that branch, and on any mismatch flushes the single wrong-path instruction and points fetch at the correct address. An unconditional jump seen in decode always redirects in the same way. When a branch is resolved in decode, a wrong guess costs exactly one fetch slot and a right guess costs nothing. A hazard stall freezes the counters, the decode slot and any redirect for that cycle.

Top module: `bpred_ctrl`

## Requirements
- R1: On reset every counter takes the value of parameter INIT_CTR (default 1, weakly not-taken) and the decode slot is empty. While the slot is empty, flush_id stays 0 and a non-branch fetch gets next_pc = if_pc + 4.
- R2: A counter value of 2 or 3 predicts taken and 0 or 1 predicts not-taken. The counter is selected by if_pc[7:2]. When if_valid and if_is_branch are high and the counter predicts taken, pred_taken is 1 and next_pc = if_target. With no decode redirect and no prediction, next_pc = if_pc + 4.
- R3: When the decode slot holds a valid conditional branch and id_stall is low, its counter moves one step up if id_taken is 1 and one step down otherwise. It clamps at 3 and at 0. The new value is used by fetches from the following cycle on.
- R4: A branch in decode that resolves taken after a not-taken prediction, or that resolves taken to an id_target different from the carried predicted target, raises flush_id in that cycle with next_pc = id_target.
- R5: A branch in decode that was predicted taken but resolves not-taken raises flush_id with next_pc = branch PC + 4.
- R6: A branch in decode whose direction (and, when taken, target) matches its prediction keeps flush_id low. next_pc then follows the fetch rule of R2.
- R7: When the decode slot holds a valid non-branch and id_is_jump is 1, flush_id is raised and next_pc = id_target. No counter changes.
- R8: A decode redirect overrides a taken prediction made in fetch in the same cycle.
- R9: While id_stall is 1: next_pc = if_pc, flush_id = 0, no counter changes, and the decode slot keeps its instruction so it resolves once the stall ends.
- R10: The instruction fetched in a flush cycle is discarded. In the following cycle the decode slot is empty, so id_is_jump or id_taken have no effect on flush_id, next_pc or the counters.
- R11: A fetch that is not a conditional branch (if_is_branch = 0), or with if_valid = 0, never predicts taken, whatever its counter holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_valid | input | 1 | Fetch stage holds a real instruction |
| if_is_branch | input | 1 | Fetched instruction is a conditional branch (predecode) |
| if_pc | input | PC_W | Address of the fetched instruction |
| if_target | input | PC_W | Branch target computed for the fetched instruction |
| id_stall | input | 1 | Hazard stall holding fetch and decode |
| id_is_jump | input | 1 | Instruction in decode is an unconditional jump |
| id_taken | input | 1 | Resolved outcome of the branch in decode |
| id_target | input | PC_W | Resolved branch or jump target in decode |
| next_pc | output | PC_W | Address to fetch in the next cycle |
| pred_taken | output | 1 | Fetch-stage prediction for the current instruction |
| flush_id | output | 1 | Squash the instruction currently in fetch |

## Verification
The bench walks one branch through every counter state. A counter that wrapped instead of clamping would flip the later predictions that the bench checks. It checks that a mispredict in decode wins over a taken prediction in fetch, and a design with the mux order reversed would fetch the wrong-path target. It checks a same-direction, different-target resolve; a design comparing only the direction would skip the flush. It stalls with a branch sitting in decode. A design that trained or redirected during the stall would show a changed prediction or a flush one cycle early. It raises jump and taken inputs in the cycle after a flush, to catch a design that fails to empty the slot. It also fetches a non-branch whose entry is already taken-leaning, and after a second reset it checks that the counters are back at their initial value.

// File: rtl/bpred_pkg.sv
`timescale 1ns/1ps
package bpred_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_MIN = 2'd0;
    localparam ctr_t CTR_MAX = 2'd3;

    // One saturating step toward taken (up=1) or not-taken (up=0).
    function automatic ctr_t ctr_step(input ctr_t c, input logic up);
        ctr_t r;
        r = c;
        if (up && c != CTR_MAX) r = c + 2'd1;
        if (!up && c != CTR_MIN) r = c - 2'd1;
        return r;
    endfunction

    // Upper bit of the counter is the taken lean.
    function automatic logic ctr_taken(input ctr_t c);
        return c[1];
    endfunction

endpackage

// File: rtl/bpred_table.sv
`timescale 1ns/1ps
module bpred_table
    import bpred_pkg::*;
#(
    parameter int   IDX_W    = 6,
    parameter ctr_t INIT_CTR = 2'd1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_t             rd_ctr,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_taken
);

    localparam int ENTRIES = 1 << IDX_W;

    logic [ENTRIES-1:0][1:0] ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        for (int e = 0; e < ENTRIES; e++) begin
            if (upd_en && upd_idx == IDX_W'(e)) begin
                ctr_d[e] = ctr_step(ctr_q[e], upd_taken);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctr_q <= {ENTRIES{INIT_CTR}};
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign rd_ctr = ctr_q[rd_idx];

    assert_sat_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_taken && ctr_q[upd_idx] == CTR_MAX)
        |=> ctr_q[$past(upd_idx)] == CTR_MAX);

    assert_sat_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !upd_taken && ctr_q[upd_idx] == CTR_MIN)
        |=> ctr_q[$past(upd_idx)] == CTR_MIN);

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> $stable(ctr_q));

endmodule

// File: rtl/bpred_slot.sv
`timescale 1ns/1ps
module bpred_slot #(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold,
    input  logic            kill,
    input  logic            in_vld,
    input  logic            in_br,
    input  logic            in_pred,
    input  logic [PC_W-1:0] in_pc,
    input  logic [PC_W-1:0] in_ptgt,
    output logic            out_vld,
    output logic            out_br,
    output logic            out_pred,
    output logic [PC_W-1:0] out_pc,
    output logic [PC_W-1:0] out_ptgt
);

    typedef struct packed {
        logic            vld;
        logic            br;
        logic            pred;
        logic [PC_W-1:0] pc;
        logic [PC_W-1:0] ptgt;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (!hold) begin
            slot_d.vld  = in_vld && !kill;
            slot_d.br   = in_br;
            slot_d.pred = in_pred;
            slot_d.pc   = in_pc;
            slot_d.ptgt = in_ptgt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign out_vld  = slot_q.vld;
    assign out_br   = slot_q.br;
    assign out_pred = slot_q.pred;
    assign out_pc   = slot_q.pc;
    assign out_ptgt = slot_q.ptgt;

    assert_kill_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (kill && !hold) |=> !out_vld);

    assert_hold_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(slot_q));

endmodule

// File: rtl/bpred_resolve.sv
`timescale 1ns/1ps
module bpred_resolve #(
    parameter int PC_W       = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic            slot_vld,
    input  logic            slot_br,
    input  logic            slot_pred,
    input  logic [PC_W-1:0] slot_pc,
    input  logic [PC_W-1:0] slot_ptgt,
    input  logic            stall,
    input  logic            is_jump,
    input  logic            taken,
    input  logic [PC_W-1:0] target,
    output logic            redirect,
    output logic [PC_W-1:0] redirect_pc,
    output logic            upd_en,
    output logic            upd_taken
);

    localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

    typedef struct packed {
        logic            redirect;
        logic [PC_W-1:0] pc;
        logic            upd;
        logic            dir;
    } res_t;

    res_t res_d;
    logic dir_wrong, tgt_wrong;

    always_comb begin
        dir_wrong = slot_pred != taken;
        tgt_wrong = slot_pred && taken && (target != slot_ptgt);
        res_d     = '0;
        if (slot_vld && !stall) begin
            if (slot_br) begin
                res_d.upd      = 1'b1;
                res_d.dir      = taken;
                res_d.redirect = dir_wrong || tgt_wrong;
                res_d.pc       = taken ? target : slot_pc + STEP;
            end else if (is_jump) begin
                res_d.redirect = 1'b1;
                res_d.pc       = target;
            end
        end
    end

    assign redirect    = res_d.redirect;
    assign redirect_pc = res_d.pc;
    assign upd_en      = res_d.upd;
    assign upd_taken   = res_d.dir;

endmodule

// File: rtl/bpred_ctrl.sv
`timescale 1ns/1ps
module bpred_ctrl
    import bpred_pkg::*;
#(
    parameter int   PC_W       = 32,
    parameter int   IDX_W      = 6,
    parameter int   INSN_BYTES = 4,
    parameter ctr_t INIT_CTR   = 2'd1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            if_valid,
    input  logic            if_is_branch,
    input  logic [PC_W-1:0] if_pc,
    input  logic [PC_W-1:0] if_target,
    input  logic            id_stall,
    input  logic            id_is_jump,
    input  logic            id_taken,
    input  logic [PC_W-1:0] id_target,
    output logic [PC_W-1:0] next_pc,
    output logic            pred_taken,
    output logic            flush_id
);

    localparam int              IDX_LSB = $clog2(INSN_BYTES);
    localparam logic [PC_W-1:0] STEP    = PC_W'(INSN_BYTES);

    typedef struct packed {
        logic [PC_W-1:0] npc;
        logic            pred;
        logic            flush;
    } out_t;

    out_t out_d;

    logic [IDX_W-1:0] f_idx, d_idx;
    ctr_t             f_ctr;
    logic             s_vld, s_br, s_pred;
    logic [PC_W-1:0]  s_pc, s_ptgt;
    logic             redir, upd_en, upd_dir;
    logic [PC_W-1:0]  redir_pc;

    assign f_idx = if_pc[IDX_LSB +: IDX_W];
    assign d_idx = s_pc[IDX_LSB +: IDX_W];

    bpred_table #(
        .IDX_W   (IDX_W),
        .INIT_CTR(INIT_CTR)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (f_idx),
        .rd_ctr   (f_ctr),
        .upd_en   (upd_en),
        .upd_idx  (d_idx),
        .upd_taken(upd_dir)
    );

    bpred_slot #(
        .PC_W(PC_W)
    ) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (id_stall),
        .kill    (redir),
        .in_vld  (if_valid),
        .in_br   (if_is_branch),
        .in_pred (out_d.pred),
        .in_pc   (if_pc),
        .in_ptgt (if_target),
        .out_vld (s_vld),
        .out_br  (s_br),
        .out_pred(s_pred),
        .out_pc  (s_pc),
        .out_ptgt(s_ptgt)
    );

    bpred_resolve #(
        .PC_W      (PC_W),
        .INSN_BYTES(INSN_BYTES)
    ) u_resolve (
        .slot_vld   (s_vld),
        .slot_br    (s_br),
        .slot_pred  (s_pred),
        .slot_pc    (s_pc),
        .slot_ptgt  (s_ptgt),
        .stall      (id_stall),
        .is_jump    (id_is_jump),
        .taken      (id_taken),
        .target     (id_target),
        .redirect   (redir),
        .redirect_pc(redir_pc),
        .upd_en     (upd_en),
        .upd_taken  (upd_dir)
    );

    // Priority: stall hold, then decode repair, then fetch guess, then sequential.
    always_comb begin
        out_d.pred  = if_valid && if_is_branch && ctr_taken(f_ctr);
        out_d.flush = redir;
        if (id_stall) begin
            out_d.npc = if_pc;
        end else if (redir) begin
            out_d.npc = redir_pc;
        end else if (out_d.pred) begin
            out_d.npc = if_target;
        end else begin
            out_d.npc = if_pc + STEP;
        end
    end

    assign next_pc    = out_d.npc;
    assign pred_taken = out_d.pred;
    assign flush_id   = out_d.flush;

    assert_stall_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        id_stall |-> (next_pc == if_pc && !flush_id));

    assert_guess_followed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_taken && !flush_id && !id_stall) |-> next_pc == if_target);

    assert_jump_redirect_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_vld && !s_br && id_is_jump && !id_stall) |-> (flush_id && next_pc == id_target));

    assert_nonbranch_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(if_valid && if_is_branch) |-> !pred_taken);

endmodule

// File: tb/sim_bpred_ctrl.sv
`timescale 1ns/1ps
module sim_bpred_ctrl;

    localparam int PC_W = 32;

    typedef struct packed {
        logic [31:0] pc;
        logic        v;
        logic        br;
        logic [31:0] tgt;
        logic        st;
        logic        jmp;
        logic        tk;
        logic [31:0] idt;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VEC [NV] = '{
        '{32'h100, 1'b1, 1'b1, 32'h200, 1'b0, 1'b0, 1'b0, 32'h0  },
        '{32'h104, 1'b1, 1'b0, 32'h0,   1'b0, 1'b0, 1'b1, 32'h200},
        '{32'h200, 1'b1, 1'b0, 32'h0,   1'b0, 1'b1, 1'b1, 32'h777},
        '{32'h100, 1'b1, 1'b1, 32'h200, 1'b0, 1'b0, 1'b0, 32'h0  },
        '{32'h200, 1'b1, 1'b0, 32'h0,   1'b0, 1'b0, 1'b1, 32'h200},
        '{32'h100, 1'b1, 1'b1, 32'h200, 1'b0, 1'b0, 1'b0, 32'h0  },
        '{32'h200, 1'b1, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 32'h0  },
        '{32'h100, 1'b1, 1'b1, 32'h200, 1'b0, 1'b0, 1'b0, 32'h0  },
        '{32'h200, 1'b1, 1'b0, 32'h0,   1'b1, 1'b0, 1'b0, 32'h0  },
        '{32'h200, 1'b1, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 32'h0  },
        '{32'h104, 1'b1, 1'b0, 32'h0,   1'b0, 1'b1, 1'b0, 32'h888},
        '{32'h108, 1'b1, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 32'h0  },
        '{32'h10c, 1'b1, 1'b0, 32'h0,   1'b0, 1'b1, 1'b0, 32'h400},
        '{32'h400, 1'b1, 1'b1, 32'h500, 1'b0, 1'b0, 1'b0, 32'h0  },
        '{32'h404, 1'b1, 1'b0, 32'h0,   1'b0, 1'b0, 1'b1, 32'h500},
        '{32'h100, 1'b1, 1'b0, 32'h200, 1'b0, 1'b0, 1'b0, 32'h0  },
        '{32'h104, 1'b1, 1'b0, 32'h0,   1'b0, 1'b0, 1'b1, 32'h0  },
        '{32'h100, 1'b1, 1'b1, 32'h200, 1'b0, 1'b0, 1'b0, 32'h0  },
        '{32'h200, 1'b1, 1'b0, 32'h0,   1'b0, 1'b0, 1'b1, 32'h300},
        '{32'h300, 1'b0, 1'b1, 32'h900, 1'b0, 1'b0, 1'b0, 32'h0  },
        '{32'h304, 1'b1, 1'b0, 32'h0,   1'b0, 1'b1, 1'b1, 32'h666},
        '{32'h100, 1'b1, 1'b1, 32'h200, 1'b0, 1'b0, 1'b0, 32'h0  },
        '{32'h100, 1'b1, 1'b1, 32'h200, 1'b0, 1'b0, 1'b0, 32'h0  },
        '{32'h104, 1'b1, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 32'h0  }
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            if_valid = 1'b0, if_is_branch = 1'b0;
    logic [PC_W-1:0] if_pc = '0, if_target = '0;
    logic            id_stall = 1'b0, id_is_jump = 1'b0, id_taken = 1'b0;
    logic [PC_W-1:0] id_target = '0;
    logic [PC_W-1:0] next_pc;
    logic            pred_taken, flush_id;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    // Reference model state
    logic [1:0]  mctr [64];
    logic        m_vld, m_br, m_pred;
    logic [31:0] m_pc, m_ptgt;

    always #10 clk = ~clk;

    bpred_ctrl u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .if_valid    (if_valid),
        .if_is_branch(if_is_branch),
        .if_pc       (if_pc),
        .if_target   (if_target),
        .id_stall    (id_stall),
        .id_is_jump  (id_is_jump),
        .id_taken    (id_taken),
        .id_target   (id_target),
        .next_pc     (next_pc),
        .pred_taken  (pred_taken),
        .flush_id    (flush_id)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 64; i++) mctr[i] = 2'd1;
        m_vld = 1'b0; m_br = 1'b0; m_pred = 1'b0; m_pc = '0; m_ptgt = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        if_valid = 1'b0; if_is_branch = 1'b0; id_stall = 1'b0;
        id_is_jump = 1'b0; id_taken = 1'b0;
        model_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step(input vec_t x);
        logic        predf, mis, upd;
        logic [31:0] corr, exp_next;
        string       tag;
        @(negedge clk);
        if_pc = x.pc; if_valid = x.v; if_is_branch = x.br; if_target = x.tgt;
        id_stall = x.st; id_is_jump = x.jmp; id_taken = x.tk; id_target = x.idt;
        #5;
        predf = x.v && x.br && mctr[x.pc[7:2]][1];
        mis = 1'b0; upd = 1'b0; corr = '0;
        if (!x.st && m_vld) begin
            if (m_br) begin
                upd  = 1'b1;
                mis  = (m_pred != x.tk) || (x.tk && m_pred && x.idt != m_ptgt);
                corr = x.tk ? x.idt : m_pc + 32'd4;
            end else if (x.jmp) begin
                mis  = 1'b1;
                corr = x.idt;
            end
        end
        exp_next = x.st ? x.pc : (mis ? corr : (predf ? x.tgt : x.pc + 32'd4));
        if (x.st) tag = "R9";
        else if (mis && predf) tag = "R8";
        else if (mis && !m_br) tag = "R7";
        else if (mis && x.tk) tag = "R4";
        else if (mis) tag = "R5";
        else if (m_vld && m_br) tag = "R6";
        else if (!m_vld && (x.jmp || x.tk)) tag = "R10";
        else if (predf) tag = "R2";
        else tag = "R1";
        check(tag, next_pc, exp_next);
        check(tag, {31'b0, flush_id}, {31'b0, mis});
        check((x.v && x.br) ? "R3" : "R11", {31'b0, pred_taken}, {31'b0, predf});
        if (!x.st) begin
            if (upd) begin
                if (x.tk && mctr[m_pc[7:2]] != 2'd3) mctr[m_pc[7:2]] = mctr[m_pc[7:2]] + 2'd1;
                if (!x.tk && mctr[m_pc[7:2]] != 2'd0) mctr[m_pc[7:2]] = mctr[m_pc[7:2]] - 2'd1;
            end
            m_vld = x.v && !mis; m_br = x.br; m_pred = predf;
            m_pc = x.pc; m_ptgt = x.tgt;
        end
    endtask

    // Train one branch: fetch it, then resolve it in decode next cycle.
    task automatic train(input logic [31:0] pc, input logic tk);
        step('{pc, 1'b1, 1'b1, pc + 32'h80, 1'b0, 1'b0, 1'b0, 32'h0});
        step('{32'h40, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0, tk, pc + 32'h80});
        step('{32'h44, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 32'h0});
    endtask

    initial begin
        model_reset();
        do_reset();
        // R1: reset state seen at the ports
        @(negedge clk);
        if_pc = 32'h100; if_valid = 1'b1; if_is_branch = 1'b1; if_target = 32'h200;
        id_is_jump = 1'b1; id_taken = 1'b1; id_target = 32'h999;
        #5;
        check("R1", {31'b0, flush_id}, 32'd0);
        check("R1", {31'b0, pred_taken}, 32'd0);
        check("R1", next_pc, 32'h104);
        @(negedge clk);
        if_valid = 1'b0; id_is_jump = 1'b0; id_taken = 1'b0;
        do_reset();

        for (int i = 0; i < NV; i++) step(VEC[i]);

        // R3: upper clamp, entry 0x180 from 1 up four times then down once
        for (int k = 0; k < 4; k++) train(32'h180, 1'b1);
        train(32'h180, 1'b0);
        step('{32'h180, 1'b1, 1'b1, 32'h900, 1'b0, 1'b0, 1'b0, 32'h0});
        check("R3", {31'b0, pred_taken}, 32'd1);
        step('{32'h900, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 32'h900});

        // R3: lower clamp, entry 0x140 down three times then up once
        for (int k = 0; k < 3; k++) train(32'h140, 1'b0);
        train(32'h140, 1'b1);
        step('{32'h140, 1'b1, 1'b1, 32'h1c0, 1'b0, 1'b0, 1'b0, 32'h0});
        check("R3", {31'b0, pred_taken}, 32'd0);
        step('{32'h144, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 32'h0});

        // R1: second reset restores the trained entry to its initial lean
        train(32'h100, 1'b1);
        do_reset();
        step('{32'h100, 1'b1, 1'b1, 32'h200, 1'b0, 1'b0, 1'b0, 32'h0});
        check("R1", {31'b0, pred_taken}, 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule